// File: doc/BRIEF.md
# Framed stream transmit adapter

This block sits between a standard AXI4-Stream packet source and the user transmit port of a framing-mode serial link. The source side numbers its 64-bit data and 8-bit byte mask in the usual descending way (`[63:0]`, `[7:0]`). The link port numbers them ascending (`[0:63]`, `[0:7]`), with position 0 as the most significant. Each accepted source beat passes through a two-entry skid buffer. The link can therefore withdraw its ready, for example while it inserts clock-compensation symbols, without any beat being dropped or repeated. The source ready comes only from how full the buffer is.

The byte mask matters only on the final beat of a frame. On every earlier beat the adapter drives an all-ones mask to the link. It also raises a one-cycle warning when the source offers a partial mask on a beat that is not last. When the link accepts the last beat of a frame, the adapter reports the frame length in bytes, with a one-cycle done pulse. The length is 8 bytes for each earlier beat plus the number of set mask bits in the last one. Reset is synchronous and active high.

Top module: `fstx_adapter`

## Requirements
- R1: While `rst` is high at a clock edge, the block empties its buffer and clears its beat counter. After that edge `lk_valid`, `frm_done` and `keep_err` are 0 and `s_ready` is 1.
- R2: A beat moves to the link only on an edge where `lk_valid` and `lk_ready` are both 1. While `lk_valid` is 1 and `lk_ready` is 0, the next cycle keeps `lk_valid` at 1 and holds `lk_data`, `lk_keep` and `lk_last` unchanged.
- R3: For every beat, `lk_data[j]` equals source bit `s_data[63-j]`. On a last beat, `lk_keep[j]` equals `s_keep[7-j]`. `lk_last` equals the `s_last` of the same beat.
- R4: On a beat whose last flag is 0, `lk_keep` is all ones, whatever `s_keep` was.
- R5: Beats reach the link in the order the source delivered them, each exactly once, under any pattern of `lk_ready`.
- R6: `s_ready` is 0 exactly when the buffer holds two beats that the link has not accepted. It does not depend combinationally on `lk_ready`.
- R7: With `lk_ready` held at 1 and the source never pausing, one beat is accepted on every clock cycle. A beat accepted into an empty buffer appears on the link in the next cycle.
- R8: `lk_valid` is 0 whenever the buffer is empty, for example while the source pauses mid-frame. A pause does not disturb the frame's running beat count.
- R9: In the cycle after the link accepts a last beat, `frm_done` is 1 for one cycle. In that cycle `frm_bytes` = 8 × (beats in the frame − 1) + number of ones in that beat's keep. `frm_done` is 0 in every other cycle.
- R10: In the cycle after the source handshakes a beat with `s_last` = 0 and `s_keep` ≠ 8'hFF, `keep_err` is 1 for one cycle. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Source beat valid |
| s_ready | output | 1 | Adapter can take a source beat |
| s_data | input | 64 | Source data, descending numbering |
| s_keep | input | 8 | Source byte mask, bit k for byte k |
| s_last | input | 1 | Source final beat of frame |
| lk_valid | output | 1 | Link beat valid |
| lk_ready | input | 1 | Link accepts the beat this cycle |
| lk_data | output | 64 | Link data, ascending numbering [0:63] |
| lk_keep | output | 8 | Link byte mask, ascending numbering [0:7] |
| lk_last | output | 1 | Link final beat of frame |
| frm_done | output | 1 | One-cycle pulse after a last beat leaves |
| frm_bytes | output | CNT_W | Byte length of the frame just finished |
| keep_err | output | 1 | One-cycle pulse for a partial mask on a non-final beat |

## Verification
The sweep runs every 8-bit mask value as the final mask, for frames of one to four beats. The same mask also goes on the earlier beats, so all-ones forcing and the warning pulse are tried against every partial pattern. Each frame length is run under four link-ready patterns: always high, alternating, pseudo-random and long stalls. Always-high ready separates full throughput from a buffer that stalls the source. The stall patterns separate correct holding and ordering from dropped or repeated beats. Some frames pause mid-frame. These show whether the beat count survives a gap and whether the link valid falls when the buffer runs dry. A bench model of buffer occupancy checks the source ready and link valid on every cycle.

// File: rtl/fstx_pkg.sv
package fstx_pkg;

    localparam int DATA_W   = 64;
    localparam int KEEP_W   = DATA_W / 8;
    localparam int POP_W    = $clog2(KEEP_W + 1);
    localparam int BYTE_SH  = $clog2(KEEP_W);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [KEEP_W-1:0] keep;
        logic              last;
    } beat_t;

    function automatic logic [POP_W-1:0] keep_ones(input logic [KEEP_W-1:0] k);
        logic [POP_W-1:0] n;
        n = '0;
        for (int i = 0; i < KEEP_W; i++) begin
            n = n + POP_W'(k[i]);
        end
        return n;
    endfunction

    function automatic logic keep_partial(input logic [KEEP_W-1:0] k);
        return k != {KEEP_W{1'b1}};
    endfunction

endpackage

// File: rtl/fstx_shape.sv
module fstx_shape
    import fstx_pkg::*;
(
    input  beat_t in_beat,
    output beat_t out_beat,
    output logic  partial_mid
);
    always_comb begin
        out_beat = in_beat;
        if (!in_beat.last) begin
            out_beat.keep = {KEEP_W{1'b1}};
        end
        partial_mid = !in_beat.last && keep_partial(in_beat.keep);
    end
endmodule

// File: rtl/fstx_skid.sv
module fstx_skid
    import fstx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    output logic  in_ready,
    input  beat_t in_beat,
    output logic  out_valid,
    input  logic  out_ready,
    output beat_t out_beat
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    beat_t          slot [DEPTH];
    logic [PW-1:0]  wr_ptr, rd_ptr;
    logic [CW-1:0]  fill;
    logic           push, pop;

    assign in_ready  = (fill != CW'(DEPTH));
    assign out_valid = (fill != '0);
    assign out_beat  = slot[rd_ptr];
    assign push      = in_valid && in_ready;
    assign pop       = out_valid && out_ready;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot[g] <= '0;
            end else if (push && wr_ptr == PW'(g)) begin
                slot[g] <= in_beat;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/fstx_framecnt.sv
module fstx_framecnt
    import fstx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              last,
    input  logic [KEEP_W-1:0] keep,
    output logic              done,
    output logic [CNT_W-1:0]  bytes
);
    logic [CNT_W-1:0] full_beats;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_beats <= '0;
            done       <= 1'b0;
            bytes      <= '0;
        end else begin
            done <= 1'b0;
            if (fire) begin
                if (last) begin
                    bytes      <= (full_beats << BYTE_SH) + CNT_W'(keep_ones(keep));
                    done       <= 1'b1;
                    full_beats <= '0;
                end else begin
                    full_beats <= full_beats + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/fstx_adapter.sv
module fstx_adapter
    import fstx_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [63:0]       s_data,
    input  logic [7:0]        s_keep,
    input  logic              s_last,
    output logic              lk_valid,
    input  logic              lk_ready,
    output logic [0:63]       lk_data,
    output logic [0:7]        lk_keep,
    output logic              lk_last,
    output logic              frm_done,
    output logic [CNT_W-1:0]  frm_bytes,
    output logic              keep_err
);
    beat_t src_beat, shaped, head;
    logic  partial_mid;

    assign src_beat = '{data: s_data, keep: s_keep, last: s_last};

    fstx_shape shape_i (
        .in_beat     (src_beat),
        .out_beat    (shaped),
        .partial_mid (partial_mid)
    );

    fstx_skid #(.DEPTH(DEPTH)) skid_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (s_valid),
        .in_ready  (s_ready),
        .in_beat   (shaped),
        .out_valid (lk_valid),
        .out_ready (lk_ready),
        .out_beat  (head)
    );

    fstx_framecnt #(.CNT_W(CNT_W)) cnt_i (
        .clk   (clk),
        .rst   (rst),
        .fire  (lk_valid && lk_ready),
        .last  (head.last),
        .keep  (head.keep),
        .done  (frm_done),
        .bytes (frm_bytes)
    );

    // Packed assignment is positional from the left: the descending source
    // bit 63 lands on ascending link bit 0, so bit k goes to link bit 63-k.
    assign lk_data = head.data;
    assign lk_keep = head.keep;
    assign lk_last = head.last;

    always_ff @(posedge clk) begin
        if (rst) keep_err <= 1'b0;
        else     keep_err <= s_valid && s_ready && partial_mid;
    end
endmodule

// File: rtl/fstx_chk.sv
module fstx_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             s_valid,
    input logic             s_ready,
    input logic [7:0]       s_keep,
    input logic             s_last,
    input logic             lk_valid,
    input logic             lk_ready,
    input logic [0:63]      lk_data,
    input logic [0:7]       lk_keep,
    input logic             lk_last,
    input logic             frm_done,
    input logic             keep_err
);
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!lk_valid && s_ready && !frm_done && !keep_err)); // R1

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !lk_ready) |=> (lk_valid && $stable(lk_data) && $stable(lk_keep) && $stable(lk_last))); // R2

    AST_MID_KEEP_FULL: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !lk_last) |-> (lk_keep == 8'hFF)); // R4

    AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !s_ready |-> lk_valid); // R6

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        frm_done |-> $past(lk_valid && lk_ready && lk_last)); // R9

    AST_KEEP_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        keep_err |-> $past(s_valid && s_ready && !s_last && (s_keep != 8'hFF))); // R10
endmodule

bind fstx_adapter fstx_chk #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .s_keep   (s_keep),
    .s_last   (s_last),
    .lk_valid (lk_valid),
    .lk_ready (lk_ready),
    .lk_data  (lk_data),
    .lk_keep  (lk_keep),
    .lk_last  (lk_last),
    .frm_done (frm_done),
    .keep_err (keep_err)
);

// File: tb/fstx_adapter_tb.sv
module fstx_adapter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int WATCHDOG   = 190000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              s_valid = 1'b0;
    logic              s_ready;
    logic [63:0]       s_data = '0;
    logic [7:0]        s_keep = '0;
    logic              s_last = 1'b0;
    logic              lk_valid;
    logic              lk_ready = 1'b0;
    logic [0:63]       lk_data;
    logic [0:7]        lk_keep;
    logic              lk_last;
    logic              frm_done;
    logic [CNT_W-1:0]  frm_bytes;
    logic              keep_err;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int rdy_mode = 0;
    bit mon_on   = 0;
    bit finished = 0;
    int occ      = 0;
    logic [72:0] expq [$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fstx_adapter #(.CNT_W(CNT_W), .DEPTH(2)) dut_i (
        .clk(clk), .rst(rst),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_keep(s_keep), .s_last(s_last),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_data(lk_data), .lk_keep(lk_keep), .lk_last(lk_last),
        .frm_done(frm_done), .frm_bytes(frm_bytes), .keep_err(keep_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int ones8(input logic [7:0] k);
        int n = 0;
        for (int i = 0; i < 8; i++) n += int'(k[i]);
        return n;
    endfunction

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    // link ready patterns, changed just after each rising edge
    initial begin
        logic [7:0] lfsr = 8'hA5;
        forever begin
            @(posedge clk); #1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            case (rdy_mode)
                0: lk_ready = 1'b1;
                1: lk_ready = cyc[0];
                2: lk_ready = lfsr[0];
                default: lk_ready = ((cyc % 16) >= 7);
            endcase
        end
    end

    // monitor and scoreboard, sampling at the falling edge
    initial begin
        bit          pend_done = 0, pend_err = 0, was_stall = 0;
        int          fbeats = 0, exp_bytes = 0;
        logic [0:63] held_d;
        logic [0:7]  held_k;
        logic        held_l;
        forever begin
            @(negedge clk);
            if (mon_on) begin
                bit fin, fout;
                fin  = s_valid && s_ready;
                fout = lk_valid && lk_ready;
                check(s_ready == (occ < 2), "R6", "source ready vs occupancy", 64'(s_ready), 64'(occ < 2));
                check(lk_valid == (occ > 0), "R8", "link valid vs occupancy", 64'(lk_valid), 64'(occ > 0));
                if (was_stall)
                    check(lk_data == held_d && lk_keep == held_k && lk_last == held_l,
                          "R2", "held beat changed", 64'(lk_data), 64'(held_d));
                was_stall = lk_valid && !lk_ready;
                held_d = lk_data; held_k = lk_keep; held_l = lk_last;
                if (pend_done)
                    check(frm_done && frm_bytes == CNT_W'(exp_bytes), "R9", "frame byte count",
                          64'({frm_done, frm_bytes}), 64'({1'b1, CNT_W'(exp_bytes)}));
                else
                    check(!frm_done, "R9", "spurious done", 64'(frm_done), 64'(0));
                check(keep_err == pend_err, "R10", "keep warning", 64'(keep_err), 64'(pend_err));
                pend_done = 0;
                if (fout) begin
                    if (expq.size() == 0) begin
                        check(0, "R5", "link beat with nothing pending", 64'(lk_data), 64'(0));
                    end else begin
                        logic [72:0] e;
                        logic [63:0] got_d;
                        logic [7:0]  got_k;
                        e = expq.pop_front();
                        for (int j = 0; j < 64; j++) got_d[63-j] = lk_data[j];
                        for (int j = 0; j < 8; j++)  got_k[7-j]  = lk_keep[j];
                        check(got_d == e[72:9] && lk_last == e[0], "R3", "data order / R5 sequence",
                              got_d, e[72:9]);
                        if (e[0])
                            check(got_k == e[8:1], "R3", "last keep order", 64'(got_k), 64'(e[8:1]));
                        else
                            check(lk_keep == 8'hFF, "R4", "mid keep forced", 64'(lk_keep), 64'hFF);
                        fbeats++;
                        if (e[0]) begin
                            pend_done = 1;
                            exp_bytes = 8 * (fbeats - 1) + ones8(e[8:1]);
                            fbeats = 0;
                        end
                    end
                end
                pend_err = fin && !s_last && (s_keep != 8'hFF);
                if (fin) expq.push_back({s_data, s_keep, s_last});
                occ = occ + int'(fin) - int'(fout);
            end
        end
    end

    // present one beat, hold it until accepted; returns just after the accepting edge
    task automatic send_beat(input logic [63:0] d, input logic [7:0] k, input logic l);
        s_valid = 1'b1; s_data = d; s_keep = k; s_last = l;
        forever begin
            @(negedge clk);
            if (s_ready) break;
        end
        @(posedge clk); #1;
    endtask

    task automatic gap(input int g);
        s_valid = 1'b0;
        repeat (g) begin @(posedge clk); #1; end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(!lk_valid && s_ready && !frm_done && !keep_err, "R1", "reset outputs",
              64'({lk_valid, s_ready, frm_done, keep_err}), 64'b0100);
        @(posedge clk); #1;
        rst = 1'b0;
        mon_on = 1;
        for (int m = 0; m < 4; m++) begin
            rdy_mode = m;
            for (int len = 1; len <= 4; len++) begin
                for (int k = 0; k < 256; k++) begin
                    int t0;
                    bit pause;
                    pause = (k % 5 == 0) && (len > 1);
                    t0 = cyc;
                    for (int b = 0; b < len; b++) begin
                        logic [63:0] d;
                        d = (64'h9E3779B97F4A7C15 * 64'(k * 8 + len + m * 4096 + 1)) ^ 64'(b);
                        send_beat(d, 8'(k), b == len - 1);
                        if (pause && b == 0) gap(3); // R8: source pause mid-frame
                    end
                    if (m == 0 && !pause)
                        check(cyc - t0 == len, "R7", "one beat per cycle", 64'(cyc - t0), 64'(len));
                    if (k % 7 == 0) gap(1);
                end
            end
        end
        gap(0);
        s_valid = 1'b0;
        rdy_mode = 0;
        repeat (8) @(posedge clk);
        @(negedge clk);
        check(expq.size() == 0, "R5", "all beats delivered", 64'(expq.size()), 64'(0));
        report();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end
endmodule